// File: doc/BRIEF.md
# Swap-Port Control Register Bank with Write Sanitising

This block holds a small set of 64-bit processor control and status registers behind a single swap-style access port. Each access names one register address. A write stores a new value and, in the same cycle, returns the value the register held before. The write also applies that register's own mask or cleaning rule. A read returns the current value with no change.

Several registers have extra behaviour:

- The exception-status register takes only its two software interrupt bits.
- The address-space register takes only its ten identifier bits. A change to it requests a translation-buffer flush.
- The timer-clear register stores nothing. It only produces a pulse that drops the timer interrupt.
- The page-walk-control register cleans its entry-width field.
- The page-size register checks its size value.
- A computed page-directory address, which cannot be written, picks a directory base from the sign bit of one of two bad-address registers.

The flush, timer-clear and illegal-configuration outputs are registered pulses. Surrounding logic (translation buffer, timer, exception entry) reacts to them.

Address map: exception-status 0x10, address-space 0x11, timer-clear 0x12, page-walk-control 0x13, page-size 0x14, refill-status 0x15, bad-address 0x16, refill bad-address 0x17, low directory base 0x18, high directory base 0x19, page-directory read 0x1A. The refill-status register, the two bad-address registers and the two directory bases are plain 64-bit registers with no masking.

Top module: `csr_swap_unit`

## Requirements
- R1: While `csr_we` or `csr_rd` is high, `csr_rdata` shows in the same cycle the value the addressed register held before the clock edge. When both strobes are low it shows zero.
- R2: A write to exception-status (0x10) changes only bits [1:0]. Bits [63:2] keep their value.
- R3: A write to address-space (0x11) changes only bits [9:0]. If the stored value changes, `tlb_flush` is high for the one cycle after the write. Otherwise it stays low.
- R4: A write to timer-clear (0x12) with bit 0 set makes `timer_clr` high for the one cycle after the write. Bit 0 clear gives no pulse. A read or write of 0x12 always returns zero.
- R5: In a write to page-walk-control (0x13), a nonzero entry-width field (bits [31:30]) is stored as zero, and `illegal_cfg` is high for the one cycle after that write.
- R6: A page size below 12 or above 48 is illegal, whether it is in the page-walk-control base field (bits [4:0]) or in the page-size field (bits [5:0]) of page-size (0x14). Such a write raises `illegal_cfg` for the one cycle after it, and the value is still stored.
- R7: A read of 0x1A selects the refill bad-address (0x17) when bit 0 of refill-status (0x15) is set, and the bad-address (0x16) otherwise. It returns the high base (0x19) if bit 63 of the selected address is 1 and the low base (0x18) if it is 0. Writes to 0x1A change nothing.
- R8: All registers reset to zero. Unmapped addresses read as zero. Writes to them change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W | Register address |
| csr_wdata | input | DATA_W | Write data |
| csr_we | input | 1 | Write (swap) strobe |
| csr_rd | input | 1 | Read strobe |
| csr_rdata | output | DATA_W | Previous/current value of addressed register |
| tlb_flush | output | 1 | One-cycle translation flush request |
| timer_clr | output | 1 | One-cycle timer interrupt clear |
| illegal_cfg | output | 1 | One-cycle illegal configuration flag |

## Verification
The bench builds the block with its default parameters: DATA_W of 64, ADDR_W of 8, and page-size limits of 12 and 48. With an 8-bit address, every possible address can be swept, so each unmapped location is shown to be inert. Every page-size value is written once, and so is every combination of entry-width field and base field. Both bounds of the legal range are therefore hit exactly. All four combinations of refill select and sign bit are driven through the directory read.

// File: rtl/csr_swap_pkg.sv
package csr_swap_pkg;
    typedef enum logic [3:0] {
        SEL_ESTAT  = 4'd0,
        SEL_ASID   = 4'd1,
        SEL_PWCTL  = 4'd2,
        SEL_PGSIZE = 4'd3,
        SEL_RFSTAT = 4'd4,
        SEL_BADA   = 4'd5,
        SEL_RFBADA = 4'd6,
        SEL_PGDLO  = 4'd7,
        SEL_PGDHI  = 4'd8,
        SEL_TCLR   = 4'd9,
        SEL_PGD    = 4'd10,
        SEL_NONE   = 4'd11
    } csr_sel_e;

    localparam int unsigned NUM_STORED = 9;

    localparam logic [7:0] A_ESTAT  = 8'h10;
    localparam logic [7:0] A_ASID   = 8'h11;
    localparam logic [7:0] A_TCLR   = 8'h12;
    localparam logic [7:0] A_PWCTL  = 8'h13;
    localparam logic [7:0] A_PGSIZE = 8'h14;
    localparam logic [7:0] A_RFSTAT = 8'h15;
    localparam logic [7:0] A_BADA   = 8'h16;
    localparam logic [7:0] A_RFBADA = 8'h17;
    localparam logic [7:0] A_PGDLO  = 8'h18;
    localparam logic [7:0] A_PGDHI  = 8'h19;
    localparam logic [7:0] A_PGD    = 8'h1A;

    localparam int unsigned ESTAT_WR_W = 2;
    localparam int unsigned ASID_WR_W  = 10;
    localparam int unsigned PTEW_LO    = 30;
    localparam int unsigned PTEW_HI    = 31;
    localparam int unsigned PTBASE_W   = 5;
    localparam int unsigned PGSZ_W     = 6;
endpackage

// File: rtl/csr_pgd_select.sv
module csr_pgd_select #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              refill_active,
    input  logic [DATA_W-1:0] bad_addr,
    input  logic [DATA_W-1:0] refill_bad_addr,
    input  logic [DATA_W-1:0] dir_lo,
    input  logic [DATA_W-1:0] dir_hi,
    output logic [DATA_W-1:0] dir_base
);
    logic sign_bit;

    always_comb begin
        sign_bit = refill_active ? refill_bad_addr[DATA_W-1] : bad_addr[DATA_W-1];
        dir_base = sign_bit ? dir_hi : dir_lo;
    end
endmodule

// File: rtl/csr_wr_sanitize.sv
module csr_wr_sanitize
    import csr_swap_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned PS_MIN = 12,
    parameter int unsigned PS_MAX = 48
) (
    input  csr_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] new_val,
    output logic              bad_cfg
);
    function automatic logic size_bad(input logic [7:0] ps);
        return (32'(ps) < PS_MIN) || (32'(ps) > PS_MAX);
    endfunction

    always_comb begin
        new_val = wdata;
        bad_cfg = 1'b0;
        unique case (sel)
            SEL_ESTAT: new_val = {old_val[DATA_W-1:ESTAT_WR_W], wdata[ESTAT_WR_W-1:0]};
            SEL_ASID:  new_val = {old_val[DATA_W-1:ASID_WR_W], wdata[ASID_WR_W-1:0]};
            SEL_PWCTL: begin
                new_val[PTEW_HI:PTEW_LO] = '0;
                bad_cfg = (wdata[PTEW_HI:PTEW_LO] != '0) ||
                          size_bad(8'(wdata[PTBASE_W-1:0]));
            end
            SEL_PGSIZE: bad_cfg = size_bad(8'(wdata[PGSZ_W-1:0]));
            default: new_val = wdata;
        endcase
    end
endmodule

// File: rtl/csr_swap_unit.sv
module csr_swap_unit
    import csr_swap_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PS_MIN = 12,
    parameter int unsigned PS_MAX = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              csr_we,
    input  logic              csr_rd,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              tlb_flush,
    output logic              timer_clr,
    output logic              illegal_cfg
);
    localparam int unsigned IDX_W = $clog2(NUM_STORED);

    csr_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] regs_q [NUM_STORED];
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;
    logic [DATA_W-1:0] dir_base;
    logic              bad_cfg;
    logic              stored;

    function automatic csr_sel_e decode(input logic [ADDR_W-1:0] a);
        csr_sel_e s;
        s = SEL_NONE;
        if      (a == ADDR_W'(A_ESTAT))  s = SEL_ESTAT;
        else if (a == ADDR_W'(A_ASID))   s = SEL_ASID;
        else if (a == ADDR_W'(A_TCLR))   s = SEL_TCLR;
        else if (a == ADDR_W'(A_PWCTL))  s = SEL_PWCTL;
        else if (a == ADDR_W'(A_PGSIZE)) s = SEL_PGSIZE;
        else if (a == ADDR_W'(A_RFSTAT)) s = SEL_RFSTAT;
        else if (a == ADDR_W'(A_BADA))   s = SEL_BADA;
        else if (a == ADDR_W'(A_RFBADA)) s = SEL_RFBADA;
        else if (a == ADDR_W'(A_PGDLO))  s = SEL_PGDLO;
        else if (a == ADDR_W'(A_PGDHI))  s = SEL_PGDHI;
        else if (a == ADDR_W'(A_PGD))    s = SEL_PGD;
        return s;
    endfunction

    always_comb begin
        sel    = decode(csr_addr);
        stored = (32'(sel) < NUM_STORED);
        idx    = stored ? IDX_W'(sel) : '0;
    end

    csr_pgd_select #(.DATA_W(DATA_W)) u_pgd (
        .refill_active   (regs_q[SEL_RFSTAT][0]),
        .bad_addr        (regs_q[SEL_BADA]),
        .refill_bad_addr (regs_q[SEL_RFBADA]),
        .dir_lo          (regs_q[SEL_PGDLO]),
        .dir_hi          (regs_q[SEL_PGDHI]),
        .dir_base        (dir_base)
    );

    always_comb begin
        if (stored)             old_val = regs_q[idx];
        else if (sel == SEL_PGD) old_val = dir_base;
        else                    old_val = '0;
        csr_rdata = (csr_we || csr_rd) ? old_val : '0;
    end

    csr_wr_sanitize #(.DATA_W(DATA_W), .PS_MIN(PS_MIN), .PS_MAX(PS_MAX)) u_san (
        .sel     (sel),
        .wdata   (csr_wdata),
        .old_val (old_val),
        .new_val (new_val),
        .bad_cfg (bad_cfg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STORED; i++) regs_q[i] <= '0;
        end else if (csr_we && stored) begin
            regs_q[idx] <= new_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlb_flush   <= 1'b0;
            timer_clr   <= 1'b0;
            illegal_cfg <= 1'b0;
        end else begin
            tlb_flush   <= csr_we && (sel == SEL_ASID) && (new_val != old_val);
            timer_clr   <= csr_we && (sel == SEL_TCLR) && csr_wdata[0];
            illegal_cfg <= csr_we && bad_cfg;
        end
    end

    p_estat_upper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel == SEL_ESTAT) |=>
            regs_q[SEL_ESTAT][DATA_W-1:ESTAT_WR_W] == $past(regs_q[SEL_ESTAT][DATA_W-1:ESTAT_WR_W]));

    p_flush_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> ($past(csr_we) && $past(sel == SEL_ASID)));

    p_flush_on_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel == SEL_ASID) |=>
            (tlb_flush == (regs_q[SEL_ASID] != $past(regs_q[SEL_ASID]))));

    p_tclr_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |-> ($past(csr_we) && $past(csr_wdata[0]) && $past(sel == SEL_TCLR)));

    p_ptew_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel == SEL_PWCTL) |=> regs_q[SEL_PWCTL][PTEW_HI:PTEW_LO] == '0);

    p_illegal_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cfg |-> ($past(csr_we) && ($past(sel == SEL_PWCTL) || $past(sel == SEL_PGSIZE))));

    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel == SEL_NONE) |=> (!tlb_flush && !timer_clr && !illegal_cfg));
endmodule

// File: tb/tb_csr_swap_unit.sv
module tb_csr_swap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [DW-1:0] csr_wdata = '0;
    logic          csr_we = 1'b0;
    logic          csr_rd = 1'b0;
    logic [DW-1:0] csr_rdata;
    logic          tlb_flush, timer_clr, illegal_cfg;

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_swap_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
        .tlb_flush(tlb_flush), .timer_clr(timer_clr), .illegal_cfg(illegal_cfg)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [DW-1:0] r_old;
    logic          r_fl, r_tc, r_il;

    task automatic op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        csr_we = w; csr_rd = !w; csr_addr = a; csr_wdata = d;
        #1 r_old = csr_rdata;
        @(posedge clk);
        #1;
        r_fl = tlb_flush; r_tc = timer_clr; r_il = illegal_cfg;
        csr_we = 1'b0; csr_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        op(1'b0, a, '0);
        chk(req, r_old, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state of every mapped register
        for (int a = 8'h10; a <= 8'h1A; a++) rd_chk("R8 reset", AW'(a), '0);
        chk("R1 idle rdata", csr_rdata, '0);

        // R2: exception-status mask
        op(1'b1, 8'h10, '1);
        chk("R2 old", r_old, '0);
        rd_chk("R2 masked", 8'h10, 64'h3);
        op(1'b1, 8'h10, 64'hFFFF_0000_0000_0001);
        chk("R1 swap old", r_old, 64'h3);
        rd_chk("R2 masked2", 8'h10, 64'h1);

        // R3: address-space mask and flush
        op(1'b1, 8'h11, 64'hABCD_0000_0000_07FF);
        chk("R3 old", r_old, '0);
        chk("R3 flush on change", 64'(r_fl), 64'd1);
        @(posedge clk); #1 chk("R3 flush one cycle", 64'(tlb_flush), 64'd0);
        rd_chk("R3 masked", 8'h11, 64'h3FF);
        op(1'b1, 8'h11, 64'h0000_0000_0000_FBFF);
        chk("R3 no flush same", 64'(r_fl), 64'd0);
        chk("R1 swap old asid", r_old, 64'h3FF);
        op(1'b1, 8'h11, 64'h155);
        chk("R3 flush change2", 64'(r_fl), 64'd1);
        rd_chk("R3 value", 8'h11, 64'h155);

        // R4: timer clear
        op(1'b1, 8'h12, 64'h1);
        chk("R4 pulse", 64'(r_tc), 64'd1);
        chk("R4 old zero", r_old, '0);
        @(posedge clk); #1 chk("R4 one cycle", 64'(timer_clr), 64'd0);
        op(1'b1, 8'h12, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R4 bit0 clear", 64'(r_tc), 64'd0);
        rd_chk("R4 read zero", 8'h12, '0);

        // R5/R6: page-walk-control sweep
        for (int w = 0; w < 4; w++) begin
            for (int b = 0; b < 32; b++) begin
                logic [DW-1:0] wv;
                wv = (64'(w) << 30) | 64'(b) | 64'hA000_0000_0000_0000;
                op(1'b1, 8'h13, wv);
                chk("R6 pwctl flag", 64'(r_il), 64'((w != 0) || (b < 12)));
                rd_chk("R5 pwctl stored", 8'h13, 64'(b) | 64'hA000_0000_0000_0000);
            end
        end

        // R6: page-size sweep
        for (int v = 0; v < 64; v++) begin
            op(1'b1, 8'h14, 64'(v));
            chk("R6 pgsize flag", 64'(r_il), 64'((v < 12) || (v > 48)));
            chk("R1 pgsize old", r_old, (v == 0) ? 64'd0 : 64'(v - 1));
        end
        rd_chk("R6 pgsize stored", 8'h14, 64'd63);

        // R7: directory select
        op(1'b1, 8'h18, 64'h1111);
        op(1'b1, 8'h19, 64'h2222);
        for (int s = 0; s < 2; s++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int which = 0; which < 2; which++) begin
                    logic [DW-1:0] bad_n, bad_r;
                    bad_n = (which == 0) ? {sg[0], 63'h5} : {!sg[0], 63'h5};
                    bad_r = (which == 0) ? {!sg[0], 63'h7} : {sg[0], 63'h7};
                    op(1'b1, 8'h15, 64'(s) | 64'h10);
                    op(1'b1, 8'h16, bad_n);
                    op(1'b1, 8'h17, bad_r);
                    rd_chk("R7 select", 8'h1A,
                        ((s == 1) ? bad_r[63] : bad_n[63]) ? 64'h2222 : 64'h1111);
                end
            end
        end
        op(1'b1, 8'h1A, 64'h9999);
        rd_chk("R7 write ignored lo", 8'h18, 64'h1111);
        rd_chk("R7 write ignored hi", 8'h19, 64'h2222);

        // R8: unmapped sweep
        for (int a = 0; a < 256; a++) begin
            if (a < 8'h10 || a > 8'h1A) begin
                op(1'b1, AW'(a), '1);
                chk("R8 unmapped old", r_old, '0);
                chk("R8 unmapped pulses", {61'd0, r_fl, r_tc, r_il}, '0);
                rd_chk("R8 unmapped read", AW'(a), '0);
            end
        end
        rd_chk("R8 estat intact", 8'h10, 64'h1);
        rd_chk("R8 asid intact", 8'h11, 64'h155);
        rd_chk("R8 pgsize intact", 8'h14, 64'd63);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule